// File: doc/BRIEF.md
# Strided Interleaved Parity Generator and Checker

This block protects a 64-bit data block with eight parity bits that are interleaved across the block. Parity group k covers every data bit whose index, taken modulo eight, equals k. Each group uses even parity, so a group's bit is the XOR of the data bits it covers. Any run of eight or fewer adjacent data bits therefore lands in eight different groups. A contiguous burst of one to eight flipped bits is always seen as one failing group per flipped bit.

The block has two paths that run side by side. The word path takes a whole 64-bit block in one cycle. It drives the generated parity vector combinationally and registers a check result against a received parity vector. The byte path takes the same block as eight bytes in sequence. Byte j carries data bits 8j+7 down to 8j, so bit k of every byte belongs to group k. A small state machine folds each byte into an 8-bit accumulator. After the eighth byte it reports the parity vector, a per-group error mask and a summary flag.

The byte path has three named states:
- IDLE waits for a start strobe.
- COLLECT counts the incoming bytes.
- REPORT presents the result for one cycle.

The transitions are:
- IDLE→COLLECT on start.
- COLLECT→COLLECT on each byte before the last, and also on a fresh start.
- COLLECT→REPORT when the eighth byte is accepted.
- REPORT→IDLE when there is no start.
- REPORT→COLLECT when a start arrives.
- Any state→COLLECT on start.

Top module: `stride_parity_unit`

## Requirements
- R1: `wd_parity[k]` is, combinationally, the XOR of `wd_data[i]` over every i with i mod 8 = k (even parity per group).
- R2: `wd_chk_valid` is 1 in the cycle after a cycle with `wd_valid` = 1 and is 0 otherwise. When it is 1, `wd_err_mask` equals the parity of the captured data XOR the captured `wd_rx_parity`, with bit k marking group k.
- R3: Whenever `wd_chk_valid` is 1, `wd_err` equals the OR of `wd_err_mask`.
- R4: If a clean block has a contiguous burst of L flipped bits (1 ≤ L ≤ 8) at any position, the error mask has exactly L bits set and the error flag is 1.
- R5: A block checked against its own correct parity gives an all-zero mask and an error flag of 0.
- R6: `bt_start` clears the accumulator and the byte count. A byte presented with `bt_valid` = 1 in the same cycle counts as the first byte of the new block.
- R7: In the cycle after the eighth accepted byte, `bt_done` is 1 for exactly one cycle. At that point `bt_parity` equals the XOR of the eight bytes, which is the same value the word path gives for the same block.
- R8: When `bt_done` is 1, `bt_err_mask` equals `bt_parity` XOR the `bt_rx_parity` that was presented with the eighth byte, and `bt_err` equals the OR of `bt_err_mask`.
- R9: A byte with `bt_valid` = 1 and `bt_start` = 0 that arrives when no block is open (in IDLE, or in REPORT) is ignored. It does not count toward a block and raises no `bt_done`.
- R10: A `bt_start` in the middle of a block drops the partial block. Completion then needs eight bytes counted from the restart.
- R11: After reset, `wd_chk_valid`, `wd_err`, `wd_err_mask`, `bt_done`, `bt_err`, `bt_err_mask` and `bt_parity` are all 0.
- R12: While `wd_valid` is 0, `wd_err_mask` and `wd_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_valid | input | 1 | Word block present for checking |
| wd_data | input | 64 | Whole data block |
| wd_rx_parity | input | 8 | Received parity vector for the word block |
| wd_parity | output | 8 | Generated parity of `wd_data` (combinational) |
| wd_chk_valid | output | 1 | Word check result valid |
| wd_err_mask | output | 8 | Failing groups of the word block |
| wd_err | output | 1 | Any word group failed |
| bt_start | input | 1 | Start of a byte-serial block |
| bt_valid | input | 1 | Byte present |
| bt_data | input | 8 | Byte of the block |
| bt_rx_parity | input | 8 | Received parity, sampled with the eighth byte |
| bt_done | output | 1 | Byte-serial result valid (one cycle) |
| bt_parity | output | 8 | Accumulated parity of the byte block |
| bt_err_mask | output | 8 | Failing groups of the byte block |
| bt_err | output | 1 | Any byte group failed |

## Verification
Two things can happen in the same clock edge: a word check can complete while the byte path takes in its eighth byte. A third case is a start strobe arriving in the same cycle as a byte. The bench sends the same block, with the same randomly placed burst, on both paths. It times the single word transfer to land on the final byte. In the next cycle it judges both results against bench-computed parity: each mask must equal the expected one, and the two paths must agree with each other. Start-with-byte and mid-block restarts are also driven, and the resulting completion cycle and parity are checked.

// File: rtl/spar_pkg.sv
package spar_pkg;
    localparam int DATA_W  = 64;
    localparam int GROUPS  = 8;
    localparam int LANES   = DATA_W / GROUPS;
    localparam int CNT_W   = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COLLECT = 2'd1,
        S_REPORT  = 2'd2
    } ser_state_t;
endpackage

// File: rtl/spar_fold.sv
module spar_fold #(
    parameter int DATA_W = 64,
    parameter int GROUPS = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [GROUPS-1:0] parity
);
    localparam int LANES = DATA_W / GROUPS;

    for (genvar k = 0; k < GROUPS; k++) begin : g_group
        logic [LANES-1:0] members;
        for (genvar j = 0; j < LANES; j++) begin : g_member
            assign members[j] = data[j*GROUPS + k];
        end
        assign parity[k] = ^members;
    end
endmodule

// File: rtl/spar_word_check.sv
module spar_word_check #(
    parameter int GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [GROUPS-1:0] calc,
    input  logic [GROUPS-1:0] rx,
    output logic              vld,
    output logic [GROUPS-1:0] mask,
    output logic              err
);
    logic [GROUPS-1:0] diff;

    always_comb begin
        diff = calc ^ rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            mask <= '0;
            err  <= 1'b0;
        end else begin
            vld <= en;
            if (en) begin
                mask <= diff;
                err  <= |diff;
            end
        end
    end
endmodule

// File: rtl/spar_byte_fsm.sv
module spar_byte_fsm
    import spar_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              valid,
    input  logic [GROUPS-1:0] din,
    input  logic [GROUPS-1:0] rx,
    output logic              done,
    output logic [GROUPS-1:0] parity,
    output logic [GROUPS-1:0] mask,
    output logic              err
);
    localparam int CW = $clog2(LANES + 1);
    localparam logic [CW-1:0] LAST = CW'(LANES - 1);

    ser_state_t        state, state_nx;
    logic [GROUPS-1:0] acc, acc_nx;
    logic [CW-1:0]     cnt, cnt_nx;
    logic              finish;
    logic [GROUPS-1:0] folded;

    always_comb begin
        folded = acc ^ din;
        finish = (state == S_COLLECT) && valid && !start && (cnt == LAST);
    end

    // next-state and datapath decode
    always_comb begin
        state_nx = state;
        acc_nx   = acc;
        cnt_nx   = cnt;
        if (start) begin
            state_nx = S_COLLECT;
            acc_nx   = valid ? din : '0;
            cnt_nx   = valid ? CW'(1) : '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    state_nx = S_IDLE;
                end
                S_COLLECT: begin
                    if (valid) begin
                        acc_nx = folded;
                        if (cnt == LAST) begin
                            state_nx = S_REPORT;
                            cnt_nx   = '0;
                        end else begin
                            cnt_nx = cnt + CW'(1);
                        end
                    end
                end
                S_REPORT: begin
                    state_nx = S_IDLE;
                    acc_nx   = '0;
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            acc   <= '0;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            acc   <= acc_nx;
            cnt   <= cnt_nx;
        end
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            parity <= '0;
            mask   <= '0;
            err    <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                parity <= folded;
                mask   <= folded ^ rx;
                err    <= |(folded ^ rx);
            end
        end
    end
endmodule

// File: rtl/stride_parity_unit.sv
module stride_parity_unit
    import spar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_valid,
    input  logic [DATA_W-1:0] wd_data,
    input  logic [GROUPS-1:0] wd_rx_parity,
    output logic [GROUPS-1:0] wd_parity,
    output logic              wd_chk_valid,
    output logic [GROUPS-1:0] wd_err_mask,
    output logic              wd_err,
    input  logic              bt_start,
    input  logic              bt_valid,
    input  logic [GROUPS-1:0] bt_data,
    input  logic [GROUPS-1:0] bt_rx_parity,
    output logic              bt_done,
    output logic [GROUPS-1:0] bt_parity,
    output logic [GROUPS-1:0] bt_err_mask,
    output logic              bt_err
);
    spar_fold #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_fold (
        .data   (wd_data),
        .parity (wd_parity)
    );

    spar_word_check #(.GROUPS(GROUPS)) u_wchk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wd_valid),
        .calc  (wd_parity),
        .rx    (wd_rx_parity),
        .vld   (wd_chk_valid),
        .mask  (wd_err_mask),
        .err   (wd_err)
    );

    spar_byte_fsm #(.GROUPS(GROUPS), .LANES(LANES)) u_bfsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bt_start),
        .valid  (bt_valid),
        .din    (bt_data),
        .rx     (bt_rx_parity),
        .done   (bt_done),
        .parity (bt_parity),
        .mask   (bt_err_mask),
        .err    (bt_err)
    );
endmodule

// File: rtl/spar_checker.sv
module spar_checker
    import spar_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wd_valid,
    input logic              wd_chk_valid,
    input logic [GROUPS-1:0] wd_err_mask,
    input logic              wd_err,
    input logic              bt_valid,
    input logic              bt_done,
    input logic [GROUPS-1:0] bt_err_mask,
    input logic              bt_err
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid |=> wd_chk_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_valid |=> !wd_chk_valid);
    a_r3_err_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
        wd_chk_valid |-> (wd_err == (|wd_err_mask)));
    a_r12_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_valid |=> $stable(wd_err_mask) && $stable(wd_err));
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bt_done |=> !bt_done);
    a_r8_err_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
        bt_done |-> (bt_err == (|bt_err_mask)));
    a_r9_done_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bt_done) |-> $past(bt_valid));
endmodule

bind stride_parity_unit spar_checker u_spar_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wd_valid     (wd_valid),
    .wd_chk_valid (wd_chk_valid),
    .wd_err_mask  (wd_err_mask),
    .wd_err       (wd_err),
    .bt_valid     (bt_valid),
    .bt_done      (bt_done),
    .bt_err_mask  (bt_err_mask),
    .bt_err       (bt_err)
);

// File: tb/sim_stride_parity_unit.sv
`timescale 1ns/1ps
module sim_stride_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wd_valid = 1'b0;
    logic [63:0] wd_data = '0;
    logic [7:0]  wd_rx_parity = '0;
    logic [7:0]  wd_parity;
    logic        wd_chk_valid;
    logic [7:0]  wd_err_mask;
    logic        wd_err;
    logic        bt_start = 1'b0;
    logic        bt_valid = 1'b0;
    logic [7:0]  bt_data = '0;
    logic [7:0]  bt_rx_parity = '0;
    logic        bt_done;
    logic [7:0]  bt_parity;
    logic [7:0]  bt_err_mask;
    logic        bt_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    stride_parity_unit u0 (.*);

    function automatic logic [7:0] ref_par(input logic [63:0] d);
        logic [7:0] p = '0;
        for (int i = 0; i < 64; i++) p[i % 8] ^= d[i];
        return p;
    endfunction

    function automatic logic [63:0] burst(input int len, input int pos);
        logic [63:0] m = '0;
        for (int i = 0; i < len; i++) m[pos + i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // send a block byte-wise; optionally launch a word check with the last byte
    task automatic send_bytes(input logic [63:0] d, input logic [7:0] rx,
                              input bit with_word, input logic [63:0] wd,
                              input logic [7:0] wrx);
        for (int j = 0; j < 8; j++) begin
            bt_start = (j == 0);
            bt_valid = 1'b1;
            bt_data  = d[j*8 +: 8];
            bt_rx_parity = rx;
            if (j == 7 && with_word) begin
                wd_valid = 1'b1;
                wd_data = wd;
                wd_rx_parity = wrx;
            end
            tick();
            if (j < 7) chk("R7 no early done", {63'd0, bt_done}, 64'd0);
        end
        bt_start = 1'b0;
        bt_valid = 1'b0;
        wd_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] d, e, flip;
        logic [7:0]  p;
        int len, pos, cnt1;
        void'($urandom(32'd20240611));
        @(negedge clk);
        tick();
        // R11 reset state
        chk("R11 wd_chk_valid", {63'd0, wd_chk_valid}, 64'd0);
        chk("R11 wd_err_mask", {56'd0, wd_err_mask}, 64'd0);
        chk("R11 bt_done", {63'd0, bt_done}, 64'd0);
        chk("R11 bt_parity", {56'd0, bt_parity}, 64'd0);
        chk("R11 bt_err", {63'd0, bt_err}, 64'd0);
        rst_n = 1'b1;
        tick();

        // R1 directed: single bits
        for (int i = 0; i < 64; i += 9) begin
            wd_data = 64'd1 << i;
            #1 chk("R1 single bit gen", {56'd0, wd_parity}, {56'd0, 8'd1 << (i % 8)});
        end
        wd_data = '1;
        #1 chk("R1 all ones gen", {56'd0, wd_parity}, 64'd0);

        // R5 clean block, R2 timing
        d = 64'h0123_4567_89AB_CDEF;
        wd_valid = 1'b1; wd_data = d; wd_rx_parity = ref_par(d);
        tick();
        wd_valid = 1'b0;
        chk("R2 chk valid", {63'd0, wd_chk_valid}, 64'd1);
        chk("R5 clean mask", {56'd0, wd_err_mask}, 64'd0);
        chk("R5 clean err", {63'd0, wd_err}, 64'd0);
        // R12 hold while idle, with data changing
        wd_data = ~d; wd_rx_parity = 8'h5A;
        tick();
        chk("R2 valid drops", {63'd0, wd_chk_valid}, 64'd0);
        chk("R12 mask holds", {56'd0, wd_err_mask}, 64'd0);

        // R4 every burst length at edges plus random positions
        for (int l = 1; l <= 8; l++) begin
            for (int t = 0; t < 3; t++) begin
                d = {$urandom(), $urandom()};
                pos = (t == 0) ? 0 : (t == 1) ? 64 - l : $urandom_range(0, 64 - l);
                flip = burst(l, pos);
                wd_valid = 1'b1; wd_data = d ^ flip; wd_rx_parity = ref_par(d);
                tick();
                wd_valid = 1'b0;
                cnt1 = $countones(wd_err_mask);
                chk("R4 burst popcount", cnt1, l);
                chk("R4 burst err", {63'd0, wd_err}, 64'd1);
                chk("R2 burst mask", {56'd0, wd_err_mask},
                    {56'd0, ref_par(d ^ flip) ^ ref_par(d)});
                chk("R3 burst flag", {63'd0, wd_err}, {63'd0, |wd_err_mask});
            end
        end

        // R7/R8 random serial blocks colliding with word checks on the last byte
        for (int n = 0; n < 40; n++) begin
            d = {$urandom(), $urandom()};
            len = $urandom_range(1, 8);
            pos = $urandom_range(0, 64 - len);
            flip = (n % 4 == 0) ? 64'd0 : burst(len, pos);
            e = d ^ flip;
            p = ref_par(d);
            send_bytes(e, p, 1'b1, e, p);
            chk("R7 done", {63'd0, bt_done}, 64'd1);
            chk("R7 parity", {56'd0, bt_parity}, {56'd0, ref_par(e)});
            chk("R8 mask", {56'd0, bt_err_mask}, {56'd0, ref_par(e) ^ p});
            chk("R8 err", {63'd0, bt_err}, {63'd0, flip != 0});
            chk("R7 paths agree", {56'd0, bt_err_mask}, {56'd0, wd_err_mask});
            chk("R2 collide valid", {63'd0, wd_chk_valid}, 64'd1);
            tick();
            chk("R7 single pulse", {63'd0, bt_done}, 64'd0);
        end

        // R9 stray bytes while idle: then a clean block must complete normally
        for (int j = 0; j < 10; j++) begin
            bt_valid = 1'b1; bt_data = 8'hFF;
            tick();
            chk("R9 stray no done", {63'd0, bt_done}, 64'd0);
        end
        bt_valid = 1'b0;

        // R6/R10 restart mid-block: 3 junk bytes, then restart with 8 bytes
        d = 64'hDEAD_BEEF_CAFE_F00D;
        for (int j = 0; j < 3; j++) begin
            bt_start = (j == 0); bt_valid = 1'b1; bt_data = 8'hA5;
            tick();
        end
        send_bytes(d, ref_par(d), 1'b0, '0, '0);
        chk("R10 restart done", {63'd0, bt_done}, 64'd1);
        chk("R6 restart parity", {56'd0, bt_parity}, {56'd0, ref_par(d)});
        chk("R10 restart err", {63'd0, bt_err}, 64'd0);

        // R6 start without byte: then 8 bytes needed
        bt_start = 1'b1; bt_valid = 1'b0;
        tick();
        bt_start = 1'b0;
        for (int j = 0; j < 8; j++) begin
            bt_valid = 1'b1; bt_data = d[j*8 +: 8];
            tick();
            if (j < 7) chk("R6 bare start no early done", {63'd0, bt_done}, 64'd0);
        end
        bt_valid = 1'b0;
        chk("R6 bare start done", {63'd0, bt_done}, 64'd1);
        chk("R6 bare start parity", {56'd0, bt_parity}, {56'd0, ref_par(d)});
        // R9 byte in REPORT is ignored: 7 more bytes give no done
        bt_valid = 1'b1; bt_data = 8'h11;
        tick();
        for (int j = 0; j < 7; j++) begin
            tick();
            chk("R9 report byte ignored", {63'd0, bt_done}, 64'd0);
        end
        bt_valid = 1'b0;
        tick();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule